// File: doc/BRIEF.md
# Indirect Legacy Register Window

This block lets software reach a small bank of legacy configuration bytes through only two bus-visible registers. A command register packs a byte offset, an access size, a read/write operation and a completion flag. A data register carries the value to store, or the value fetched. Software writes a command and polls the command register until the completion flag is set. For a read, it then collects the result from the data register.

The backing access waits a programmable number of cycles before it completes, so software polling is exercised. Commands that are malformed finish at once and leave the register file untouched. The first six bytes of the file hold a station address. Writes to those bytes are collected in a staging buffer and become visible only once six address bytes have been written. Writing zero to the status byte resets the device state. That command still completes normally, and the window stays usable afterwards.

Top module: `indirect_reg_window`

## Requirements
- R1: After reset, the command register and the data register both read zero, and every register-file byte is zero.
- R2: The command register holds the offset in bits [15:0], the size in bits [19:16], the operation in bit [20] (0 = read, 1 = write) and completion in bit [31]. All other bits read as zero. A completion bit written by software is discarded, and completion reads zero once a valid command has been accepted.
- R3: A read returns file byte offset+i in data bits [8i+7:8i] for i below size. Bits above the size read zero. Any byte offset is allowed, including unaligned ones.
- R4: A write stores data bits [8i+7:8i] into file byte offset+i for each i below size. A later read returns the stored bytes.
- R5: A valid command sets completion exactly cfgLatency+1 clock cycles after the edge that accepts it. Completion stays clear until then.
- R6: While a valid command is pending, writes to the command register and to the data register are ignored.
- R7: A size other than 1, 2 or 4, or an access with offset+size greater than 24, sets completion on the accepting edge and changes no file byte. A read of this kind returns 0xFFFFFFFF.
- R8: Writes to bytes 0 to 5 are staged and counted. Reads of those bytes keep returning the old values until the count reaches six. The staged bytes are then applied together and the count returns to zero.
- R9: A write of 0x00 to status byte 18 completes normally. It clears every register-file byte, the staging buffer and the address byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Bus write strobe |
| busSel | input | 1 | Register select: 0 = command, 1 = data |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Contents of the selected register |
| cfgLatency | input | 3 | Backing access latency minus one |

## Verification
The hardest case to reach is a device reset that lands while the address staging counter holds a partial count. In that state, a counter that is not cleared would merge old and new bytes. The stimulus stages one address byte, issues the zero write to the status byte, then writes five fresh address bytes and checks that nothing is applied. A sixth byte must then apply all of them. Commands that arrive while a long-latency access is in flight are driven a few cycles after acceptance, so the ignored command and data writes fall inside the pending window.

// File: rtl/iw_pkg.sv
package iw_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic        access;   // perform the latched access this cycle
    logic        bad;      // malformed command accepted this cycle
    logic        isWrite;  // operation of the access or the bad command
    logic [15:0] offset;
    logic [2:0]  size;
  } iw_stb_t;
endpackage

// File: rtl/iw_ctrl.sv
module iw_ctrl
  import iw_pkg::*;
#(
  parameter int REG_BYTES = 24,
  parameter int LAT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrlWrEn,
  input  logic [31:0]      wdata,
  input  logic [LAT_W-1:0] cfgLatency,
  output iw_stb_t          stb,
  output logic [31:0]      ctrlRd,
  output logic             busy
);
  localparam int SUM_W = 17;

  logic [15:0]      offQ;
  logic [3:0]       sizeQ;
  logic             opQ;
  logic             cmplQ;
  logic [LAT_W-1:0] cntQ;

  logic [15:0] cmdOff;
  logic [3:0]  cmdSize;
  logic        cmdOp;
  logic        sizeOk;
  logic        rangeOk;
  logic        cmdOk;
  logic        accept;

  assign cmdOff  = wdata[15:0];
  assign cmdSize = wdata[19:16];
  assign cmdOp   = wdata[20];
  assign sizeOk  = (cmdSize == 4'd1) || (cmdSize == 4'd2) || (cmdSize == 4'd4);
  assign rangeOk = ({1'b0, cmdOff} + SUM_W'(cmdSize)) <= SUM_W'(REG_BYTES);
  assign cmdOk   = sizeOk && rangeOk;
  assign accept  = ctrlWrEn && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offQ  <= '0;
      sizeQ <= '0;
      opQ   <= 1'b0;
      cmplQ <= 1'b0;
      busy  <= 1'b0;
      cntQ  <= '0;
    end else if (accept) begin
      offQ  <= cmdOff;
      sizeQ <= cmdSize;
      opQ   <= cmdOp;
      cmplQ <= !cmdOk;
      busy  <= cmdOk;
      cntQ  <= cfgLatency;
    end else if (busy) begin
      if (cntQ == '0) begin
        busy  <= 1'b0;
        cmplQ <= 1'b1;
      end else begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

  always_comb begin
    stb.access  = busy && (cntQ == '0);
    stb.bad     = accept && !cmdOk;
    stb.isWrite = accept ? cmdOp : opQ;
    stb.offset  = offQ;
    stb.size    = sizeQ[2:0];
  end

  assign ctrlRd = {cmplQ, 10'b0, opQ, sizeQ, offQ};
endmodule

// File: rtl/iw_datapath.sv
module iw_datapath
  import iw_pkg::*;
#(
  parameter int REG_BYTES  = 24,
  parameter int MAC_BYTES  = 6,
  parameter int STATUS_OFF = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dataWrEn,
  input  logic [31:0] wdata,
  input  iw_stb_t     stb,
  output logic [31:0] dataRd
);
  localparam int IDX_W = $clog2(REG_BYTES);
  localparam int CNT_W = $clog2(MAC_BYTES + 5);
  localparam int LANES = 4;

  logic [7:0]       memQ   [REG_BYTES];
  logic [7:0]       memD   [REG_BYTES];
  logic [7:0]       stageQ [MAC_BYTES];
  logic [7:0]       stageD [MAC_BYTES];
  logic [CNT_W-1:0] macCntQ, macCntD;
  logic [31:0]      dataQ, dataD;
  logic             devRst;

  always_comb begin
    memD    = memQ;
    stageD  = stageQ;
    macCntD = macCntQ;
    dataD   = dataQ;
    devRst  = 1'b0;
    if (dataWrEn) dataD = wdata;
    if (stb.bad && !stb.isWrite) dataD = '1;
    if (stb.access && !stb.isWrite) begin
      dataD = '0;
      for (int i = 0; i < LANES; i++) begin
        if (i < int'(stb.size) && int'(stb.offset) + i < REG_BYTES)
          dataD[8*i +: 8] = memQ[IDX_W'(int'(stb.offset) + i)];
      end
    end
    if (stb.access && stb.isWrite) begin
      for (int i = 0; i < LANES; i++) begin
        if (i < int'(stb.size) && int'(stb.offset) + i < REG_BYTES) begin
          if (int'(stb.offset) + i < MAC_BYTES) begin
            stageD[IDX_W'(int'(stb.offset) + i)] = dataQ[8*i +: 8];
            macCntD = macCntD + 1'b1;
          end else begin
            memD[IDX_W'(int'(stb.offset) + i)] = dataQ[8*i +: 8];
            if (int'(stb.offset) + i == STATUS_OFF && dataQ[8*i +: 8] == 8'h00)
              devRst = 1'b1;
          end
        end
      end
      if (devRst) begin
        for (int b = 0; b < REG_BYTES; b++) memD[b] = '0;
        for (int b = 0; b < MAC_BYTES; b++) stageD[b] = '0;
        macCntD = '0;
      end else if (int'(macCntD) >= MAC_BYTES) begin
        for (int b = 0; b < MAC_BYTES; b++) memD[b] = stageD[b];
        macCntD = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < REG_BYTES; b++) memQ[b] <= '0;
      for (int b = 0; b < MAC_BYTES; b++) stageQ[b] <= '0;
      macCntQ <= '0;
      dataQ   <= '0;
    end else begin
      memQ    <= memD;
      stageQ  <= stageD;
      macCntQ <= macCntD;
      dataQ   <= dataD;
    end
  end

  assign dataRd = dataQ;
endmodule

// File: rtl/indirect_reg_window.sv
module indirect_reg_window
  import iw_pkg::*;
#(
  parameter int REG_BYTES  = 24,
  parameter int MAC_BYTES  = 6,
  parameter int STATUS_OFF = 18,
  parameter int LAT_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busWrEn,
  input  logic             busSel,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic [LAT_W-1:0] cfgLatency
);
  iw_stb_t     stb;
  logic [31:0] ctrlRdVal;
  logic [31:0] dataRdVal;
  logic        busy;
  logic        ctrlWrEn;
  logic        dataWrEn;

  assign ctrlWrEn = busWrEn && !busSel;
  assign dataWrEn = busWrEn && busSel && !busy;

  iw_ctrl #(.REG_BYTES(REG_BYTES), .LAT_W(LAT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrlWrEn(ctrlWrEn), .wdata(busWdata),
    .cfgLatency(cfgLatency), .stb(stb), .ctrlRd(ctrlRdVal), .busy(busy)
  );

  iw_datapath #(.REG_BYTES(REG_BYTES), .MAC_BYTES(MAC_BYTES),
                .STATUS_OFF(STATUS_OFF)) u_dp (
    .clk(clk), .rst_n(rst_n), .dataWrEn(dataWrEn), .wdata(busWdata),
    .stb(stb), .dataRd(dataRdVal)
  );

  assign busRdata = busSel ? dataRdVal : ctrlRdVal;
endmodule

// File: rtl/iw_checker.sv
module iw_checker #(
  parameter int REG_BYTES = 24
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrlRd,
  input logic [31:0] dataRd,
  input logic        busy,
  input logic        badStb
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlRd[30:21] == 10'b0);

  // R5
  busy_no_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ctrlRd[31]);

  // R6
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ctrlRd[20:0]));

  // R7
  bad_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    badStb |=> ctrlRd[31] && !busy);

  // R3
  narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrlRd[31]) && !ctrlRd[20] && ctrlRd[19:16] == 4'd1 &&
    int'(ctrlRd[15:0]) < REG_BYTES |-> dataRd[31:8] == 24'b0);
endmodule

bind indirect_reg_window iw_checker #(.REG_BYTES(REG_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrlRd(ctrlRdVal), .dataRd(dataRdVal),
  .busy(busy), .badStb(stb.bad)
);

// File: tb/indirect_reg_window_tb.sv
module indirect_reg_window_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busSel = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  cfgLatency = 3'd0;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  indirect_reg_window u_dut (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busSel(busSel),
    .busWdata(busWdata), .busRdata(busRdata), .cfgLatency(cfgLatency)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic sel, input logic [31:0] val);
    @(negedge clk);
    busSel = sel; busWdata = val; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic sel, output logic [31:0] val);
    busSel = sel;
    #1;
    val = busRdata;
  endtask

  function automatic logic [31:0] cmdWord(input int off, input int size, input bit wr);
    return {11'b0, wr, 4'(size), 16'(off)};
  endfunction

  task automatic runCmd(input int off, input int size, input bit wr,
                        input logic [31:0] wval, output logic [31:0] rd);
    logic [31:0] v;
    bit done;
    done = 1'b0;
    if (wr) busWrite(1'b1, wval);
    busWrite(1'b0, cmdWord(off, size, wr));
    for (int k = 0; k < 40 && !done; k++) begin
      busRead(1'b0, v);
      if (v[31]) done = 1'b1;
      else @(negedge clk);
    end
    nChecks++;
    if (!done) begin
      nFails++;
      $display("FAIL R5: actual 0x%08h expected completion set", v);
    end
    busRead(1'b1, rd);
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRead(1'b0, v); check("R1 ctrl", v, 32'h0);
    busRead(1'b1, v); check("R1 data", v, 32'h0);
    runCmd(8, 4, 1'b0, 0, v); check("R1 file", v, 32'h0);
  endtask

  task automatic testFields();
    logic [31:0] v;
    cfgLatency = 3'd0;
    busWrite(1'b0, 32'hFFE1_0008);
    busRead(1'b0, v); check("R2 layout", v, 32'h0001_0008);
    repeat (2) @(negedge clk);
    busRead(1'b0, v); check("R2 done", v, 32'h8001_0008);
  endtask

  task automatic testReadWrite();
    logic [31:0] v;
    runCmd(8, 4, 1'b1, 32'hA1B2_C3D4, v);
    runCmd(8, 4, 1'b0, 0, v);  check("R4 word", v, 32'hA1B2_C3D4);
    runCmd(10, 4, 1'b0, 0, v); check("R3 unaligned", v, 32'h0000_A1B2);
    runCmd(9, 2, 1'b0, 0, v);  check("R3 half", v, 32'h0000_B2C3);
    runCmd(9, 1, 1'b0, 0, v);  check("R3 byte", v, 32'h0000_00C3);
  endtask

  task automatic testLatency();
    logic [31:0] v;
    cfgLatency = 3'd5;
    busWrite(1'b0, cmdWord(8, 1, 1'b0));
    busRead(1'b0, v); check("R5 j0", {31'b0, v[31]}, 32'h0);
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      busRead(1'b0, v);
      check($sformatf("R5 j%0d", j), {31'b0, v[31]}, (j == 6) ? 32'h1 : 32'h0);
    end
    cfgLatency = 3'd0;
  endtask

  task automatic testBusyIgnore();
    logic [31:0] v;
    cfgLatency = 3'd7;
    busWrite(1'b1, 32'h1234_5678);
    busWrite(1'b0, cmdWord(12, 4, 1'b1));
    busWrite(1'b0, cmdWord(0, 1, 1'b0));
    busWrite(1'b1, 32'hDEAD_BEEF);
    repeat (8) @(negedge clk);
    busRead(1'b0, v); check("R6 ctrl", v, 32'h8014_000C);
    cfgLatency = 3'd0;
    runCmd(12, 4, 1'b0, 0, v); check("R6 data", v, 32'h1234_5678);
  endtask

  task automatic testBad();
    logic [31:0] v;
    busWrite(1'b0, cmdWord(0, 3, 1'b0));
    busRead(1'b0, v); check("R7 fast", {31'b0, v[31]}, 32'h1);
    busRead(1'b1, v); check("R7 ones", v, 32'hFFFF_FFFF);
    runCmd(22, 4, 1'b1, 32'h5555_5555, v);
    runCmd(22, 2, 1'b0, 0, v); check("R7 untouched", v, 32'h0);
    runCmd(23, 2, 1'b0, 0, v); check("R7 range", v, 32'hFFFF_FFFF);
  endtask

  task automatic testMac();
    logic [31:0] v;
    runCmd(0, 4, 1'b1, 32'h4433_2211, v);
    runCmd(0, 4, 1'b0, 0, v); check("R8 staged", v, 32'h0);
    runCmd(4, 2, 1'b1, 32'h0000_6655, v);
    runCmd(2, 4, 1'b0, 0, v); check("R8 applied", v, 32'h6655_4433);
    runCmd(0, 2, 1'b0, 0, v); check("R8 low", v, 32'h0000_2211);
    runCmd(0, 1, 1'b1, 32'h0000_0099, v);
    runCmd(0, 1, 1'b0, 0, v); check("R8 count reset", v, 32'h0000_0011);
  endtask

  task automatic testDevReset();
    logic [31:0] v;
    runCmd(18, 1, 1'b1, 32'h0000_000F, v);
    runCmd(18, 1, 1'b0, 0, v); check("R9 status", v, 32'h0000_000F);
    runCmd(18, 1, 1'b1, 32'h0000_0000, v);
    runCmd(8, 4, 1'b0, 0, v); check("R9 file", v, 32'h0);
    runCmd(0, 4, 1'b0, 0, v); check("R9 mac", v, 32'h0);
    runCmd(0, 4, 1'b1, 32'hCCBB_AA77, v);
    runCmd(4, 1, 1'b1, 32'h0000_00EE, v);
    runCmd(0, 4, 1'b0, 0, v); check("R9 counter", v, 32'h0);
    runCmd(5, 1, 1'b1, 32'h0000_00FF, v);
    runCmd(2, 4, 1'b0, 0, v); check("R9 reapply", v, 32'hFFEE_CCBB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testFields();
    testReadWrite();
    testLatency();
    testBusyIgnore();
    testBad();
    testMac();
    testDevReset();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule